// File: doc/BRIEF.md
# Glitch-free PLL post-divider controller

This block is the digital output stage placed after a PLL oscillator. It receives the fast oscillator clock, a reference clock, a slow alternate clock, a lock flag and a bypass request. When the loop is locked and bypass is not requested, the main output is the oscillator clock divided by a programmable post-divisor. In every other state the main output carries a bypass clock. That bypass clock is either the reference divided by a second programmable value plus one, or the slow alternate clock.

Both divisors can be rewritten at any moment. A new value is taken into the running counter only when the current output period ends, so no output phase is ever cut short. Each divisor has a status bit that flips once for every value that is taken in. A post-divisor written while the loop is unlocked or bypassed waits, and is taken in only after locked operation resumes.

Besides the main output there is an undivided oscillator output and an auxiliary copy of the divided clock. Both are held low unless the loop is locked and bypass is off. Each output has its own enable input. That enable is resynchronised and applied only while the clock is low. A matching activity flag reports whether the gate is really open.

Top module: `pll_postdiv`

## Requirements
- R1: In locked operation with bypass off, `clk_main` has a period of D oscillator cycles, where D is the active post-divisor, and a high phase of ceil(D/2) oscillator cycles. Written values 0 and 1 act as D = 2.
- R2: In locked operation with `dco_en` high, `clk_dco` toggles at the oscillator rate.
- R3: A post-divisor change takes effect only where the current output period ends. The counter never leaves the range of the active divisor, and no high or low phase of `clk_main` or `clk_aux` is shorter than one oscillator cycle, including across source switches.
- R4: `m2_ack` flips exactly once for each accepted post-divisor. A write that lands in the wrap cycle is accepted at that wrap. Several writes within one period are accepted as the last of them, with a single flip.
- R5: A post-divisor written while unlocked or in bypass does not flip `m2_ack`. It is accepted, with a flip, after locked operation with bypass off resumes, and the new period is then visible on `clk_main`.
- R6: While unlocked or bypassed with `low_clk_sel` = 0, `clk_main` has a period of (N2+1) reference cycles and a high phase of ceil((N2+1)/2) reference cycles. N2 = 0 acts like N2 = 1.
- R7: While unlocked or bypassed with `low_clk_sel` = 1, `clk_main` follows `clk_low`.
- R8: A bypass divisor write is accepted at the end of the current bypass period, and `n2_ack` flips once.
- R9: `clk_aux` carries the post-divided clock in locked operation. `clk_aux` and `clk_dco` stay low while unlocked or bypassed.
- R10: With an output's enable low, that output stays low and its activity flag is 0.
- R11: With an output's enable high and its source running, the activity flag becomes 1. It is 1 only if the gate was open one source edge earlier.
- R12: The switch between two clock sources is break-before-make: the two source enables are never on together.
- R13: During reset all clock outputs are low, all activity flags are 0 and both acknowledge bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Fast oscillator clock |
| clk_ref | input | 1 | Reference clock |
| clk_low | input | 1 | Alternate slow clock |
| rst | input | 1 | Synchronous active-high reset (clocks must run) |
| pll_locked | input | 1 | Loop lock flag (asynchronous) |
| bypass_req | input | 1 | Bypass request (asynchronous) |
| low_clk_sel | input | 1 | Bypass source: 0 divided reference, 1 slow clock |
| m2_wdata | input | 6 | New post-divisor |
| m2_wr | input | 1 | Post-divisor write strobe, `clk_osc` domain |
| n2_wdata | input | 6 | New bypass divisor N2 (divides by N2+1) |
| n2_wr | input | 1 | Bypass divisor write strobe, `clk_ref` domain |
| main_en | input | 1 | Gate enable for `clk_main` |
| dco_en | input | 1 | Gate enable for `clk_dco` |
| aux_en | input | 1 | Gate enable for `clk_aux` |
| m2_ack | output | 1 | Flips on each accepted post-divisor |
| n2_ack | output | 1 | Flips on each accepted bypass divisor |
| clk_main | output | 1 | Main output clock |
| clk_dco | output | 1 | Undivided oscillator output |
| clk_aux | output | 1 | Auxiliary post-divided output |
| main_act | output | 1 | `clk_main` gate activity |
| dco_act | output | 1 | `clk_dco` gate activity |
| aux_act | output | 1 | `clk_aux` gate activity |

## Verification
The counter wrap and a post-divisor write can fall in the same oscillator cycle. The write must then be taken at that wrap, not left pending for a full period. The bench provokes this by waiting a random number of oscillator cycles, drawn from a fixed seed, before each write, so that over the run writes fall on every phase of the period. Each write is judged by three things: `m2_ack` flips exactly once, the next measured period and high phase match the value written, and a pulse-width monitor sees no phase shorter than one oscillator cycle.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
    // width of a written divisor field
    localparam int DIV_W  = 6;
    // internal counter width: one extra bit so the bypass value N2+1 fits
    localparam int CNT_W  = DIV_W + 1;
    // resynchroniser depth
    localparam int SYNC_N = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    // programmed divider state: active value and a pending value
    typedef struct packed {
        cnt_t cur;
        cnt_t pend;
        logic pend_vld;
    } div_cfg_t;

    // values below two cannot be made with a single-edge counter
    function automatic cnt_t eff_div(cnt_t d);
        return (d < cnt_t'(2)) ? cnt_t'(2) : d;
    endfunction

    // high phase length: ceil(d/2)
    function automatic cnt_t high_len(cnt_t d);
        logic [CNT_W:0] t;
        t = {1'b0, d} + 1'b1;
        return t[CNT_W:1];
    endfunction
endpackage

// File: rtl/pdc_sync.sv
`timescale 1ns/1ps
module pdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) sh[i] <= 1'b0;
                    else     sh[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) sh[i] <= 1'b0;
                    else     sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pdc_divider.sv
`timescale 1ns/1ps
module pdc_divider
    import pdc_pkg::*;
#(
    parameter cnt_t RST_DIV = cnt_t'(4)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,      // asynchronous permission to accept new values
    input  logic wr,
    input  cnt_t wdata,
    output logic clk_div,
    output logic ack
);
    logic     run_s;
    div_cfg_t cfg, cfg_n;
    cnt_t     cnt, cnt_n;
    logic     out_n, ack_n, wrap;

    pdc_sync #(.STAGES(SYNC_N)) u_run_sync (
        .clk(clk), .rst(rst), .d(run), .q(run_s)
    );

    // last input cycle of the current output period
    assign wrap = (cnt == cfg.cur - cnt_t'(1));

    always_comb begin
        cfg_n = cfg;
        cnt_n = cnt + cnt_t'(1);
        ack_n = ack;
        if (wr) begin
            cfg_n.pend     = wdata;
            cfg_n.pend_vld = 1'b1;
        end
        if (wrap) begin
            cnt_n = '0;
            // a write in the wrap cycle itself is taken directly
            if (run_s && (wr || cfg.pend_vld)) begin
                cfg_n.cur      = eff_div(wr ? wdata : cfg.pend);
                cfg_n.pend_vld = 1'b0;
                ack_n          = ~ack;
            end
        end
        out_n = (cnt_n < high_len(cfg_n.cur));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{cur: eff_div(RST_DIV), pend: '0, pend_vld: 1'b0};
            cnt     <= '0;
            clk_div <= 1'b0;
            ack     <= 1'b0;
        end else begin
            cfg     <= cfg_n;
            cnt     <= cnt_n;
            clk_div <= out_n;
            ack     <= ack_n;
        end
    end

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg.cur);

    // R3
    div_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg.cur));

    // R4
    div_ack_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ack != $past(ack)) |-> $past(wrap && run_s));
endmodule

// File: rtl/pdc_clk_switch.sv
`timescale 1ns/1ps
module pdc_clk_switch (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic clk_out
);
    logic a_req, a_en, b_req, b_en;

    // each side asks only once the other side has released
    always_ff @(posedge clk_a or posedge rst) begin
        if (rst) a_req <= 1'b0;
        else     a_req <= !sel_b && !b_en;
    end
    always_ff @(negedge clk_a or posedge rst) begin
        if (rst) a_en <= 1'b0;
        else     a_en <= a_req;
    end

    always_ff @(posedge clk_b or posedge rst) begin
        if (rst) b_req <= 1'b0;
        else     b_req <= sel_b && !a_en;
    end
    always_ff @(negedge clk_b or posedge rst) begin
        if (rst) b_en <= 1'b0;
        else     b_en <= b_req;
    end

    assign clk_out = (clk_a & a_en) | (clk_b & b_en);

    always_comb begin
        if (!rst) begin
            // R12
            sw_bbm_chk: assert (!(a_en && b_en));
        end
    end
endmodule

// File: rtl/pdc_gate.sv
`timescale 1ns/1ps
module pdc_gate
    import pdc_pkg::*;
(
    input  logic clk_src,
    input  logic rst,
    input  logic en,
    output logic clk_out,
    output logic act
);
    logic en_s, gate_q, seen;

    pdc_sync #(.STAGES(SYNC_N)) u_en_sync (
        .clk(clk_src), .rst(rst), .d(en), .q(en_s)
    );

    // the gate moves only while the source is low
    always_ff @(negedge clk_src or posedge rst) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= en_s;
    end

    // activity: set on the second forwarded edge, cleared on the first
    // source edge after closing
    always_ff @(posedge clk_src or posedge rst) begin
        if (rst) begin
            seen <= 1'b0;
            act  <= 1'b0;
        end else begin
            seen <= gate_q;
            act  <= gate_q && seen;
        end
    end

    assign clk_out = clk_src & gate_q;

    // R11
    gate_act_chk: assert property (@(posedge clk_src) disable iff (rst)
        act |-> $past(gate_q));

    // R10
    gate_close_chk: assert property (@(posedge clk_src) disable iff (rst)
        !gate_q |=> !act);
endmodule

// File: rtl/pll_postdiv.sv
`timescale 1ns/1ps
module pll_postdiv
    import pdc_pkg::*;
#(
    parameter logic [DIV_W-1:0] M2_RST = DIV_W'(4),
    parameter logic [DIV_W-1:0] N2_RST = DIV_W'(1)
) (
    input  logic             clk_osc,
    input  logic             clk_ref,
    input  logic             clk_low,
    input  logic             rst,
    input  logic             pll_locked,
    input  logic             bypass_req,
    input  logic             low_clk_sel,
    input  logic [DIV_W-1:0] m2_wdata,
    input  logic             m2_wr,
    input  logic [DIV_W-1:0] n2_wdata,
    input  logic             n2_wr,
    input  logic             main_en,
    input  logic             dco_en,
    input  logic             aux_en,
    output logic             m2_ack,
    output logic             n2_ack,
    output logic             clk_main,
    output logic             clk_dco,
    output logic             clk_aux,
    output logic             main_act,
    output logic             dco_act,
    output logic             aux_act
);
    localparam cnt_t M2_RST_C = cnt_t'({1'b0, M2_RST});
    localparam cnt_t N2_RST_C = cnt_t'({1'b0, N2_RST}) + cnt_t'(1);

    logic pll_run;
    logic m2_clk, ref_div_clk, byp_clk, main_src;
    cnt_t m2_val, n2_val;

    assign pll_run = pll_locked && !bypass_req;
    assign m2_val  = cnt_t'({1'b0, m2_wdata});
    assign n2_val  = cnt_t'({1'b0, n2_wdata}) + cnt_t'(1);

    // post-divider on the oscillator; accepts only in locked operation
    pdc_divider #(.RST_DIV(M2_RST_C)) u_m2_div (
        .clk(clk_osc), .rst(rst), .run(pll_run),
        .wr(m2_wr), .wdata(m2_val),
        .clk_div(m2_clk), .ack(m2_ack)
    );

    // bypass divider on the reference; always accepts
    pdc_divider #(.RST_DIV(N2_RST_C)) u_n2_div (
        .clk(clk_ref), .rst(rst), .run(1'b1),
        .wr(n2_wr), .wdata(n2_val),
        .clk_div(ref_div_clk), .ack(n2_ack)
    );

    pdc_clk_switch u_byp_sw (
        .clk_a(ref_div_clk), .clk_b(clk_low), .rst(rst),
        .sel_b(low_clk_sel), .clk_out(byp_clk)
    );

    pdc_clk_switch u_main_sw (
        .clk_a(byp_clk), .clk_b(m2_clk), .rst(rst),
        .sel_b(pll_run), .clk_out(main_src)
    );

    pdc_gate u_main_gate (
        .clk_src(main_src), .rst(rst), .en(main_en),
        .clk_out(clk_main), .act(main_act)
    );

    pdc_gate u_dco_gate (
        .clk_src(clk_osc), .rst(rst), .en(dco_en && pll_run),
        .clk_out(clk_dco), .act(dco_act)
    );

    pdc_gate u_aux_gate (
        .clk_src(m2_clk), .rst(rst), .en(aux_en && pll_run),
        .clk_out(clk_aux), .act(aux_act)
    );
endmodule

// File: tb/sim_pll_postdiv.sv
`timescale 1ns/1ps
module sim_pll_postdiv;
    logic       clk_osc = 1'b0, clk_ref = 1'b0, clk_low = 1'b0;
    logic       rst = 1'b1;
    logic       pll_locked = 1'b0, bypass_req = 1'b0, low_clk_sel = 1'b0;
    logic [5:0] m2_wdata = '0, n2_wdata = '0;
    logic       m2_wr = 1'b0, n2_wr = 1'b0;
    logic       main_en = 1'b1, dco_en = 1'b1, aux_en = 1'b1;
    logic       m2_ack, n2_ack, clk_main, clk_dco, clk_aux;
    logic       main_act, dco_act, aux_act;

    int  n_chk = 0, n_fail = 0;
    int  e_main = 0, e_dco = 0, e_aux = 0, runts = 0, m2_flips = 0;
    real main_r = -1.0e6, main_f = -1.0e6, aux_r = -1.0e6, aux_f = -1.0e6;
    bit  done = 1'b0;

    pll_postdiv u0 (
        .clk_osc(clk_osc), .clk_ref(clk_ref), .clk_low(clk_low), .rst(rst),
        .pll_locked(pll_locked), .bypass_req(bypass_req), .low_clk_sel(low_clk_sel),
        .m2_wdata(m2_wdata), .m2_wr(m2_wr), .n2_wdata(n2_wdata), .n2_wr(n2_wr),
        .main_en(main_en), .dco_en(dco_en), .aux_en(aux_en),
        .m2_ack(m2_ack), .n2_ack(n2_ack), .clk_main(clk_main), .clk_dco(clk_dco),
        .clk_aux(clk_aux), .main_act(main_act), .dco_act(dco_act), .aux_act(aux_act)
    );

    // 50 MHz oscillator; reference and slow clock never share an edge with it
    always #10 clk_osc = ~clk_osc;
    initial begin #7;  forever #35  clk_ref = ~clk_ref; end
    initial begin #3;  forever #115 clk_low = ~clk_low; end

    // edge counters and pulse-width monitor (R3)
    always @(posedge clk_main) begin
        e_main++;
        if ($realtime - main_f < 19.5) runts++;
        main_r = $realtime;
    end
    always @(negedge clk_main) begin
        if ($realtime - main_r < 19.5) runts++;
        main_f = $realtime;
    end
    always @(posedge clk_aux) begin
        e_aux++;
        if ($realtime - aux_f < 19.5) runts++;
        aux_r = $realtime;
    end
    always @(negedge clk_aux) begin
        if ($realtime - aux_r < 19.5) runts++;
        aux_f = $realtime;
    end
    always @(posedge clk_dco) e_dco++;
    always @(posedge clk_osc) begin
        if (!rst && m2_ack !== u_prev_ack) m2_flips++;
        u_prev_ack = m2_ack;
    end
    logic u_prev_ack = 1'b0;

    function automatic int eff(int v);
        return (v < 2) ? 2 : v;
    endfunction
    function automatic int hi_of(int d);
        return (d + 1) / 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input real actual, input real expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0.1f expected=%0.1f", req, what, actual, expected);
        end
    endtask

    task automatic chk_near(input string req, input string what,
                            input real actual, input real expected);
        chk((actual - expected < 0.5) && (expected - actual < 0.5), req, what, actual, expected);
    endtask

    // which: 0 main, 1 dco, 2 aux
    task automatic meas(input int which, output real hi, output real per);
        real t0, t1, t2;
        case (which)
            0: begin @(posedge clk_main); t0 = $realtime; @(negedge clk_main);
                     t1 = $realtime; @(posedge clk_main); t2 = $realtime; end
            1: begin @(posedge clk_dco); t0 = $realtime; @(negedge clk_dco);
                     t1 = $realtime; @(posedge clk_dco); t2 = $realtime; end
            default: begin @(posedge clk_aux); t0 = $realtime; @(negedge clk_aux);
                     t1 = $realtime; @(posedge clk_aux); t2 = $realtime; end
        endcase
        hi  = t1 - t0;
        per = t2 - t0;
    endtask

    task automatic write_m2(input int v);
        @(negedge clk_osc);
        m2_wdata = 6'(v);
        m2_wr    = 1'b1;
        @(negedge clk_osc);
        m2_wr    = 1'b0;
    endtask

    task automatic write_n2(input int v);
        @(negedge clk_ref);
        n2_wdata = 6'(v);
        n2_wr    = 1'b1;
        @(negedge clk_ref);
        n2_wr    = 1'b0;
    endtask

    task automatic wait_m2_ack(input logic old, input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk_osc);
            if (m2_ack !== old) begin got = 1'b1; break; end
        end
    endtask

    task automatic expect_main(input string req, input real e_hi, input real e_per);
        real hi, per;
        meas(0, hi, per);
        chk_near(req, "main period", per, e_per);
        chk_near(req, "main high", hi, e_hi);
    endtask

    // one post-divisor write after a random delay, then judge ack and period
    task automatic m2_trial(input int v, input int delay, input string req);
        logic old;
        bit   got;
        int   f0;
        for (int i = 0; i < delay; i++) @(negedge clk_osc);
        old = m2_ack;
        f0  = m2_flips;
        write_m2(v);
        wait_m2_ack(old, 200, got);
        chk(got, req, "m2_ack flip", real'(got), 1.0);
        for (int i = 0; i < 40; i++) @(negedge clk_osc);
        chk(m2_flips - f0 == 1, req, "flip count", real'(m2_flips - f0), 1.0);
        expect_main("R1", real'(hi_of(eff(v)) * 20), real'(eff(v) * 20));
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        #(150000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        real  hi, per;
        int   em, ed, ea;
        logic old;
        bit   got;

        // reset window: R13
        for (int i = 0; i < 20; i++) @(negedge clk_osc);
        chk(clk_main === 1'b0 && clk_dco === 1'b0 && clk_aux === 1'b0, "R13",
            "clocks low in reset", real'(clk_main), 0.0);
        chk({main_act, dco_act, aux_act} === 3'b000, "R13", "activity in reset",
            real'({main_act, dco_act, aux_act}), 0.0);
        chk({m2_ack, n2_ack} === 2'b00, "R13", "acks in reset", real'({m2_ack, n2_ack}), 0.0);
        chk(e_main == 0, "R13", "main edges in reset", real'(e_main), 0.0);
        rst = 1'b0;

        // bypass from the divided reference, N2 = 1: R6, R11, R9
        #3000;
        expect_main("R6", 70.0, 140.0);
        @(negedge clk_osc);
        chk(main_act === 1'b1, "R11", "main_act open", real'(main_act), 1.0);
        ed = e_dco; ea = e_aux;
        #2000;
        chk(e_dco == ed, "R9", "dco low unlocked", real'(e_dco - ed), 0.0);
        chk(e_aux == ea, "R9", "aux low unlocked", real'(e_aux - ea), 0.0);

        // bypass divisor rewrite: R8, R6
        old = n2_ack;
        write_n2(2);
        for (int i = 0; i < 10; i++) @(negedge clk_ref);
        chk(n2_ack !== old, "R8", "n2_ack flip", real'(n2_ack), real'(~old));
        #1000;
        expect_main("R6", 140.0, 210.0);
        old = n2_ack;
        write_n2(0);
        for (int i = 0; i < 10; i++) @(negedge clk_ref);
        chk(n2_ack !== old, "R8", "n2_ack flip N2=0", real'(n2_ack), real'(~old));
        #1000;
        expect_main("R6", 70.0, 140.0);

        // slow alternate clock: R7
        low_clk_sel = 1'b1;
        #3000;
        expect_main("R7", 115.0, 230.0);
        low_clk_sel = 1'b0;
        #3000;

        // lock: R1, R2, R9, R11
        pll_locked = 1'b1;
        #2000;
        expect_main("R1", 40.0, 80.0);
        meas(1, hi, per);
        chk_near("R2", "dco period", per, 20.0);
        meas(2, hi, per);
        chk_near("R9", "aux period", per, 80.0);
        @(negedge clk_osc);
        chk(dco_act === 1'b1 && aux_act === 1'b1, "R11", "dco/aux active",
            real'({dco_act, aux_act}), 3.0);

        // fixed-seed random writes with random phase, incl. values 0/1: R4, R1, R3
        for (int k = 0; k < 14; k++) begin
            int v;
            v = ($urandom % 5 == 0) ? int'($urandom % 2) : 2 + int'($urandom % 12);
            m2_trial(v, int'($urandom % 13), "R4");
        end
        // directed wrap-phase sweep with an odd divisor
        for (int d = 0; d < 7; d++) m2_trial((d % 2 == 0) ? 7 : 4, d, "R4");

        // two writes inside one long period: single flip, last wins (R4)
        m2_trial(13, 0, "R4");
        @(posedge clk_main);
        @(negedge clk_osc);
        old = m2_ack;
        em  = m2_flips;
        write_m2(9);
        write_m2(5);
        wait_m2_ack(old, 200, got);
        for (int i = 0; i < 40; i++) @(negedge clk_osc);
        chk(m2_flips - em == 1, "R4", "superseded writes flip once", real'(m2_flips - em), 1.0);
        expect_main("R4", 60.0, 100.0);

        // write while bypassed: R5, R9
        bypass_req = 1'b1;
        #2000;
        old = m2_ack;
        write_m2(6);
        for (int i = 0; i < 300; i++) @(negedge clk_osc);
        chk(m2_ack === old, "R5", "no accept in bypass", real'(m2_ack), real'(old));
        ea = e_aux;
        #1000;
        chk(e_aux == ea, "R9", "aux low in bypass", real'(e_aux - ea), 0.0);
        expect_main("R5", 70.0, 140.0);
        bypass_req = 1'b0;
        wait_m2_ack(old, 200, got);
        chk(got, "R5", "accept after relock", real'(got), 1.0);
        #2000;
        expect_main("R5", 60.0, 120.0);

        // gating: R10, R11
        main_en = 1'b0;
        #1000;
        em = e_main;
        #1000;
        @(negedge clk_osc);
        chk(e_main == em && clk_main === 1'b0, "R10", "main stopped", real'(e_main - em), 0.0);
        chk(main_act === 1'b0, "R10", "main_act closed", real'(main_act), 0.0);
        main_en = 1'b1;
        #1000;
        @(negedge clk_osc);
        chk(main_act === 1'b1, "R11", "main_act reopened", real'(main_act), 1.0);
        dco_en = 1'b0;
        #500;
        ed = e_dco;
        #500;
        @(negedge clk_osc);
        chk(e_dco == ed, "R10", "dco stopped", real'(e_dco - ed), 0.0);
        chk(dco_act === 1'b0, "R10", "dco_act closed", real'(dco_act), 0.0);

        // unlock back to bypass: R6
        pll_locked = 1'b0;
        #3000;
        expect_main("R6", 70.0, 140.0);

        // no runt phase anywhere in the run: R3, R12
        chk(runts == 0, "R3", "runt pulses", real'(runts), 0.0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule